// File: doc/BRIEF.md
# Cash Machine Transaction Controller

This block is the sequencing core of a small cash machine. It reads a bank of slide switches and five button pulses, one clock cycle each and already debounced. It first asks for an 8-bit PIN. Once the PIN is accepted, it offers five services: show the balance, withdraw cash, deposit cash, deposit a check, or replace the PIN. The block holds the account balance and the current PIN in registers of its own. Every amount is checked against fixed rules before the balance changes.

Its outputs drive a separate display path. That path converts the value to decimal and scans the digits, and neither task is part of this block. The controller supplies three things: a binary display value, a mode code that says whether the value is a plain number, a blinking number or an error code, and a blank strobe that carries the blink. When an amount is accepted, it blinks for a fixed hold time, 5 s at 100 MHz by default. After that the new balance stays on screen until Enter is pressed.

Top module: `atm_ctrl`

## Requirements
- R1: After reset the controller waits for a PIN. The stored PIN is DEF_PIN (8'h00), the balance is START_BAL, `disp_mode` is 0 (number), `disp_value` is 0 and `disp_blank` is 0.
- R2: In PIN entry, Enter with `sw[7:0]` equal to the stored PIN moves to the service menu. Any other value shows mode 2 (error) with code 1 and stays in PIN entry, so the user can try again.
- R3: In the menu, `disp_value` is 0 in mode 0. The buttons select services as follows: up selects balance inquiry, right selects withdrawal, left selects cash deposit, down selects check deposit, and Enter selects PIN change.
- R4: Balance inquiry shows the balance in mode 0. Enter returns to the menu.
- R5: In withdrawal and cash deposit, the amount starts at 0 and is shown in mode 0. Each press adds a fixed sum: up adds 10, right adds 20, left adds 50, down adds 100. The amount saturates at 2^AMT_W-1 (4095).
- R6: A withdrawal whose amount is not a multiple of 20, or is larger than 500, shows error code 2. The balance does not change.
- R7: A withdrawal that passes R6 but is larger than the balance shows error code 3. The balance does not change.
- R8: A cash deposit that would take the balance above 1500 shows error code 4. The balance does not change and the pending amount is cleared.
- R9: For a check deposit, the amount is read from the switches as BCD: `sw[3:0]` is units, `sw[7:4]` is tens and `sw[11:8]` is hundreds. While in this state, the converted value is shown in mode 0, or 0 if any digit is above 9. On Enter, a digit above 9 gives error code 2 and a sum above 1500 gives error code 4. Otherwise the value is added to the balance.
- R10: An accepted amount is shown in mode 1 (blink) for exactly HOLD_CYC cycles. The updated balance then follows in mode 0, and Enter returns to the menu. Buttons have no effect during the blink.
- R11: `disp_blank` is 0 in the first blink cycle and inverts every BLINK_CYC cycles during the blink. It is 0 at all other times.
- R12: PIN change compares `sw[7:0]` with the stored PIN on Enter. If they are equal, it shows error code 5 and keeps the PIN. Otherwise it stores the new PIN and returns to the menu.
- R13: On an error screen only Enter has an effect, and it returns to the menu. The next amount entry starts from 0.
- R14: The balance never exceeds MAX_BAL (1500).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | SW_W (12) | Slide switches: PIN on [7:0], check amount as three BCD digits |
| btn_up | input | 1 | Up button pulse |
| btn_right | input | 1 | Right button pulse |
| btn_left | input | 1 | Left button pulse |
| btn_down | input | 1 | Down button pulse |
| btn_enter | input | 1 | Centre (Enter) button pulse |
| disp_value | output | AMT_W (12) | Binary value or error code to show |
| disp_mode | output | 2 | 0 number, 1 blinking number, 2 error code |
| disp_blank | output | 1 | Blanks the digits during the off phase of the blink |

## Verification
On every cycle the assertions check four things. The balance stays under its ceiling. The PIN and the balance keep their values except on a commit. Error screens leave on Enter, and blink expiry leads to the balance screen. The blank strobe appears only in blink mode and changes only on its phase boundary. Only the bench's scenarios can show the rest. That covers the arithmetic of each rule (the multiple-of-20 test, the funds and ceiling tests, BCD digit validity), the order of the checks when more than one rule fails, saturation of the amount, and how long the hold lasts and what it shows. The bench's reference model follows each of these cycle by cycle.

// File: rtl/atm_pkg.sv
package atm_pkg;

   typedef enum logic [3:0] {
      ST_PIN,
      ST_MENU,
      ST_BAL,
      ST_WDR,
      ST_DEP,
      ST_CHK,
      ST_NEWPIN,
      ST_HOLD,
      ST_SHOW,
      ST_ERR
   } atm_state_e;

   typedef enum logic [1:0] {
      DM_NUM   = 2'd0,
      DM_BLINK = 2'd1,
      DM_ERR   = 2'd2
   } disp_mode_e;

   typedef enum logic [2:0] {
      EC_NONE    = 3'd0,
      EC_PIN     = 3'd1,
      EC_AMOUNT  = 3'd2,
      EC_FUNDS   = 3'd3,
      EC_LIMIT   = 3'd4,
      EC_SAMEPIN = 3'd5
   } err_code_e;

endpackage

// File: rtl/atm_amount_acc.sv
module atm_amount_acc #(
   parameter int          AMT_W = 12,
   parameter int unsigned D0    = 10,
   parameter int unsigned D1    = 20,
   parameter int unsigned D2    = 50,
   parameter int unsigned D3    = 100
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             add_en,
   input  logic [3:0]       key,
   output logic [AMT_W-1:0] amount
);
   localparam int          SUM_W     = AMT_W + 3;
   localparam int unsigned DENOMS[4] = '{D0, D1, D2, D3};
   localparam logic [SUM_W-1:0] CAP  = SUM_W'({AMT_W{1'b1}});

   for (genvar g = 0; g < 4; g++) begin : g_denom_chk
      if (DENOMS[g] == 0 || DENOMS[g] >= (1 << AMT_W)) begin : g_bad
         $error("denomination %0d out of range", g);
      end
   end

   logic [SUM_W-1:0] step;
   logic [SUM_W-1:0] total;
   logic [AMT_W-1:0] acc_q;

   always_comb begin
      step = '0;
      for (int i = 0; i < 4; i++) begin
         if (key[i]) step = step + SUM_W'(DENOMS[i]);
      end
      total = SUM_W'(acc_q) + step;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         acc_q <= '0;
      end else if (add_en) begin
         acc_q <= (total > CAP) ? CAP[AMT_W-1:0] : total[AMT_W-1:0];
      end
   end

   assign amount = acc_q;

   // R5
   acc_mono_chk: assert property (@(posedge clk) disable iff (rst)
      (add_en && !clr) |=> (amount >= $past(amount)));

   // R13
   acc_clr_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> (amount == '0));

endmodule

// File: rtl/atm_bcd2bin.sv
module atm_bcd2bin #(
   parameter int DIGITS = 3,
   parameter int OUT_W  = 12
) (
   input  logic [4*DIGITS-1:0] bcd,
   output logic [OUT_W-1:0]    value,
   output logic                valid
);
   if (DIGITS < 1 || (10 ** DIGITS) > (2 ** OUT_W)) begin : g_bad_width
      $error("BCD digit count does not fit the output width");
   end

   logic [OUT_W-1:0]  term [DIGITS];
   logic [DIGITS-1:0] digit_ok;

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      localparam int unsigned WEIGHT = 10 ** g;
      assign digit_ok[g] = (bcd[4*g +: 4] <= 4'd9);
      assign term[g]     = OUT_W'(bcd[4*g +: 4]) * OUT_W'(WEIGHT);
   end

   always_comb begin
      value = '0;
      for (int i = 0; i < DIGITS; i++) value = value + term[i];
   end

   assign valid = &digit_ok;

endmodule

// File: rtl/atm_hold_timer.sv
module atm_hold_timer #(
   parameter int unsigned HOLD_CYC  = 500_000_000,
   parameter int unsigned BLINK_CYC = 25_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic done,
   output logic blank
);
   localparam int CW = $clog2(HOLD_CYC + 1);
   localparam int PW = $clog2(BLINK_CYC + 1);

   if (HOLD_CYC < 1 || BLINK_CYC < 1) begin : g_bad_timing
      $error("hold and blink periods must be at least one cycle");
   end

   logic          run_q;
   logic [CW-1:0] cnt_q;
   logic [PW-1:0] ph_q;
   logic          blank_q;
   logic          ph_wrap;

   assign done    = run_q && (cnt_q == CW'(HOLD_CYC - 1));
   assign ph_wrap = (ph_q == PW'(BLINK_CYC - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q   <= 1'b0;
         cnt_q   <= '0;
         ph_q    <= '0;
         blank_q <= 1'b0;
      end else if (start) begin
         run_q   <= 1'b1;
         cnt_q   <= '0;
         ph_q    <= '0;
         blank_q <= 1'b0;
      end else if (run_q) begin
         if (done) begin
            run_q   <= 1'b0;
            blank_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (ph_wrap) begin
               ph_q    <= '0;
               blank_q <= ~blank_q;
            end else begin
               ph_q <= ph_q + 1'b1;
            end
         end
      end
   end

   assign blank = run_q && blank_q;

   // R10
   hold_range_chk: assert property (@(posedge clk) disable iff (rst)
      run_q |-> (cnt_q < CW'(HOLD_CYC)));

   // R11
   blank_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !run_q |-> !blank);

   // R11
   blank_phase_chk: assert property (@(posedge clk) disable iff (rst)
      (run_q && !start && !done && !ph_wrap) |=> $stable(blank));

endmodule

// File: rtl/atm_ctrl.sv
module atm_ctrl
   import atm_pkg::*;
#(
   parameter int               PIN_W       = 8,
   parameter int               SW_W        = 12,
   parameter int               AMT_W       = 12,
   parameter int unsigned      START_BAL   = 200,
   parameter int unsigned      MAX_BAL     = 1500,
   parameter int unsigned      MAX_WDR     = 500,
   parameter int unsigned      WDR_STEP    = 20,
   parameter int unsigned      DENOM_UP    = 10,
   parameter int unsigned      DENOM_RIGHT = 20,
   parameter int unsigned      DENOM_LEFT  = 50,
   parameter int unsigned      DENOM_DOWN  = 100,
   parameter int unsigned      HOLD_CYC    = 500_000_000,
   parameter int unsigned      BLINK_CYC   = 25_000_000,
   parameter logic [PIN_W-1:0] DEF_PIN     = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SW_W-1:0]  sw,
   input  logic             btn_up,
   input  logic             btn_right,
   input  logic             btn_left,
   input  logic             btn_down,
   input  logic             btn_enter,
   output logic [AMT_W-1:0] disp_value,
   output logic [1:0]       disp_mode,
   output logic             disp_blank
);
   localparam int DIGITS = SW_W / 4;
   localparam int SUM_W  = AMT_W + 1;

   if (SW_W % 4 != 0 || SW_W < PIN_W) begin : g_bad_sw
      $error("switch width must hold the PIN and whole BCD digits");
   end
   if (MAX_BAL >= (1 << AMT_W) || START_BAL > MAX_BAL || MAX_WDR > MAX_BAL) begin : g_bad_limits
      $error("balance limits do not fit the amount width");
   end
   if (WDR_STEP == 0) begin : g_bad_step
      $error("withdrawal step must be non-zero");
   end

   atm_state_e       state_q, state_d;
   logic [PIN_W-1:0] pin_q, pin_d;
   logic [AMT_W-1:0] bal_q, bal_d;
   logic [AMT_W-1:0] amt_q, amt_d;
   logic [2:0]       err_q, err_d;
   logic             pin_err_q, pin_err_d;

   logic [AMT_W-1:0] acc;
   logic             acc_clr;
   logic             acc_add;
   logic [AMT_W-1:0] chk_value;
   logic             chk_ok;
   logic             tmr_start;
   logic             tmr_done;
   logic             tmr_blank;
   logic [AMT_W-1:0] cand;
   logic [SUM_W-1:0] bal_sum;
   logic             pin_match;

   atm_amount_acc #(
      .AMT_W (AMT_W),
      .D0    (DENOM_UP),
      .D1    (DENOM_RIGHT),
      .D2    (DENOM_LEFT),
      .D3    (DENOM_DOWN)
   ) u_acc (
      .clk    (clk),
      .rst    (rst),
      .clr    (acc_clr),
      .add_en (acc_add),
      .key    ({btn_down, btn_left, btn_right, btn_up}),
      .amount (acc)
   );

   atm_bcd2bin #(
      .DIGITS (DIGITS),
      .OUT_W  (AMT_W)
   ) u_bcd (
      .bcd   (sw[4*DIGITS-1:0]),
      .value (chk_value),
      .valid (chk_ok)
   );

   atm_hold_timer #(
      .HOLD_CYC  (HOLD_CYC),
      .BLINK_CYC (BLINK_CYC)
   ) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .start (tmr_start),
      .done  (tmr_done),
      .blank (tmr_blank)
   );

   assign pin_match = (sw[PIN_W-1:0] == pin_q);
   assign acc_add   = ((state_q == ST_WDR) || (state_q == ST_DEP)) && !btn_enter;
   assign cand      = (state_q == ST_CHK) ? chk_value : acc;
   assign bal_sum   = SUM_W'(bal_q) + SUM_W'(cand);

   always_comb begin
      state_d   = state_q;
      pin_d     = pin_q;
      bal_d     = bal_q;
      amt_d     = amt_q;
      err_d     = err_q;
      pin_err_d = pin_err_q;
      tmr_start = 1'b0;
      acc_clr   = (state_q == ST_MENU);
      case (state_q)
         ST_PIN: begin
            if (btn_enter) begin
               if (pin_match) begin
                  state_d   = ST_MENU;
                  pin_err_d = 1'b0;
               end else begin
                  pin_err_d = 1'b1;
               end
            end
         end
         ST_MENU: begin
            if (btn_up)         state_d = ST_BAL;
            else if (btn_right) state_d = ST_WDR;
            else if (btn_left)  state_d = ST_DEP;
            else if (btn_down)  state_d = ST_CHK;
            else if (btn_enter) state_d = ST_NEWPIN;
         end
         ST_BAL, ST_SHOW, ST_ERR: begin
            if (btn_enter) state_d = ST_MENU;
         end
         ST_WDR: begin
            if (btn_enter) begin
               if ((acc % AMT_W'(WDR_STEP)) != '0 || acc > AMT_W'(MAX_WDR)) begin
                  state_d = ST_ERR;
                  err_d   = EC_AMOUNT;
                  acc_clr = 1'b1;
               end else if (acc > bal_q) begin
                  state_d = ST_ERR;
                  err_d   = EC_FUNDS;
                  acc_clr = 1'b1;
               end else begin
                  bal_d     = bal_q - acc;
                  amt_d     = acc;
                  state_d   = ST_HOLD;
                  tmr_start = 1'b1;
               end
            end
         end
         ST_DEP, ST_CHK: begin
            if (btn_enter) begin
               if (state_q == ST_CHK && !chk_ok) begin
                  state_d = ST_ERR;
                  err_d   = EC_AMOUNT;
                  acc_clr = 1'b1;
               end else if (bal_sum > SUM_W'(MAX_BAL)) begin
                  state_d = ST_ERR;
                  err_d   = EC_LIMIT;
                  acc_clr = 1'b1;
               end else begin
                  bal_d     = bal_sum[AMT_W-1:0];
                  amt_d     = cand;
                  state_d   = ST_HOLD;
                  tmr_start = 1'b1;
               end
            end
         end
         ST_NEWPIN: begin
            if (btn_enter) begin
               if (pin_match) begin
                  state_d = ST_ERR;
                  err_d   = EC_SAMEPIN;
               end else begin
                  pin_d   = sw[PIN_W-1:0];
                  state_d = ST_MENU;
               end
            end
         end
         ST_HOLD: begin
            if (tmr_done) state_d = ST_SHOW;
         end
         default: state_d = ST_PIN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_PIN;
         pin_q     <= DEF_PIN;
         bal_q     <= AMT_W'(START_BAL);
         amt_q     <= '0;
         err_q     <= EC_NONE;
         pin_err_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         pin_q     <= pin_d;
         bal_q     <= bal_d;
         amt_q     <= amt_d;
         err_q     <= err_d;
         pin_err_q <= pin_err_d;
      end
   end

   always_comb begin
      disp_value = '0;
      disp_mode  = DM_NUM;
      disp_blank = 1'b0;
      case (state_q)
         ST_PIN: begin
            if (pin_err_q) begin
               disp_mode  = DM_ERR;
               disp_value = AMT_W'(EC_PIN);
            end
         end
         ST_BAL, ST_SHOW: disp_value = bal_q;
         ST_WDR, ST_DEP:  disp_value = acc;
         ST_CHK:          disp_value = chk_ok ? chk_value : '0;
         ST_HOLD: begin
            disp_mode  = DM_BLINK;
            disp_value = amt_q;
            disp_blank = tmr_blank;
         end
         ST_ERR: begin
            disp_mode  = DM_ERR;
            disp_value = AMT_W'(err_q);
         end
         default: disp_value = '0;
      endcase
   end

   // R14
   bal_cap_chk: assert property (@(posedge clk) disable iff (rst)
      bal_q <= AMT_W'(MAX_BAL));

   // R12
   pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(state_q == ST_NEWPIN && btn_enter) |=> $stable(pin_q));

   // R2
   pin_retry_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_PIN && btn_enter && !pin_match) |=> (state_q == ST_PIN && disp_mode == DM_ERR));

   // R13
   err_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ERR && btn_enter) |=> (state_q == ST_MENU));

   // R6 R7 R8
   err_bal_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ERR) |-> $stable(bal_q));

   // R10
   hold_show_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_HOLD && tmr_done) |=> (state_q == ST_SHOW && disp_mode == DM_NUM));

   // R11
   blank_mode_chk: assert property (@(posedge clk) disable iff (rst)
      disp_blank |-> (disp_mode == DM_BLINK));

endmodule

// File: tb/test_atm_ctrl.sv
module test_atm_ctrl;
   localparam int H      = 20;
   localparam int B      = 4;
   localparam int START  = 200;
   localparam int DEFPIN = 0;

   localparam int M_PIN = 0, M_MENU = 1, M_BAL = 2, M_WDR = 3, M_DEP = 4,
                  M_CHK = 5, M_NEWPIN = 6, M_HOLD = 7, M_SHOW = 8, M_ERR = 9;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] sw  = '0;
   logic [4:0]  b   = '0;   // 0 up, 1 right, 2 left, 3 down, 4 enter
   logic [11:0] disp_value;
   logic [1:0]  disp_mode;
   logic        disp_blank;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    cmp_on  = 1'b0;
   bit    ended   = 1'b0;
   string cur_req = "R1";

   int m_st, m_pin, m_bal, m_acc, m_amt, m_err, m_perr, m_el;

   always #4 clk = ~clk;

   atm_ctrl #(.HOLD_CYC(H), .BLINK_CYC(B)) i_atm_ctrl (
      .clk(clk), .rst(rst), .sw(sw),
      .btn_up(b[0]), .btn_right(b[1]), .btn_left(b[2]), .btn_down(b[3]), .btn_enter(b[4]),
      .disp_value(disp_value), .disp_mode(disp_mode), .disp_blank(disp_blank)
   );

   function automatic bit bcd_ok(input logic [11:0] s);
      return (s[3:0] <= 9) && (s[7:4] <= 9) && (s[11:8] <= 9);
   endfunction

   function automatic int bcd_val(input logic [11:0] s);
      return int'(s[11:8]) * 100 + int'(s[7:4]) * 10 + int'(s[3:0]);
   endfunction

   task automatic m_fail(input int code);
      m_st  = M_ERR;
      m_err = code;
      m_acc = 0;
   endtask

   task automatic m_accept(input int v);
      m_amt = v;
      m_st  = M_HOLD;
      m_el  = 0;
   endtask

   // reference model
   always @(posedge clk) begin
      int add;
      if (rst) begin
         m_st = M_PIN; m_pin = DEFPIN; m_bal = START; m_acc = 0;
         m_amt = 0; m_err = 0; m_perr = 0; m_el = 0;
      end else begin
         add = (b[0] ? 10 : 0) + (b[1] ? 20 : 0) + (b[2] ? 50 : 0) + (b[3] ? 100 : 0);
         case (m_st)
            M_PIN: if (b[4]) begin
               if (int'(sw[7:0]) == m_pin) begin m_st = M_MENU; m_perr = 0; end
               else m_perr = 1;
            end
            M_MENU: begin
               m_acc = 0;
               if (b[0]) m_st = M_BAL;
               else if (b[1]) m_st = M_WDR;
               else if (b[2]) m_st = M_DEP;
               else if (b[3]) m_st = M_CHK;
               else if (b[4]) m_st = M_NEWPIN;
            end
            M_BAL, M_SHOW, M_ERR: if (b[4]) m_st = M_MENU;
            M_WDR: begin
               if (b[4]) begin
                  if (m_acc % 20 != 0 || m_acc > 500) m_fail(2);
                  else if (m_acc > m_bal) m_fail(3);
                  else begin m_bal = m_bal - m_acc; m_accept(m_acc); end
               end else begin
                  m_acc = (m_acc + add > 4095) ? 4095 : m_acc + add;
               end
            end
            M_DEP: begin
               if (b[4]) begin
                  if (m_bal + m_acc > 1500) m_fail(4);
                  else begin m_bal = m_bal + m_acc; m_accept(m_acc); end
               end else begin
                  m_acc = (m_acc + add > 4095) ? 4095 : m_acc + add;
               end
            end
            M_CHK: if (b[4]) begin
               if (!bcd_ok(sw)) m_fail(2);
               else if (m_bal + bcd_val(sw) > 1500) m_fail(4);
               else begin m_bal = m_bal + bcd_val(sw); m_accept(bcd_val(sw)); end
            end
            M_NEWPIN: if (b[4]) begin
               if (int'(sw[7:0]) == m_pin) m_fail(5);
               else begin m_pin = int'(sw[7:0]); m_st = M_MENU; end
            end
            M_HOLD: begin
               if (m_el == H - 1) m_st = M_SHOW;
               else m_el = m_el + 1;
            end
            default: m_st = M_PIN;
         endcase
      end
   end

   task automatic check(input string req, input string what, input int got, input int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      int ev, em, eb;
      #1;
      if (cmp_on && !rst) begin
         ev = 0; em = 0; eb = 0;
         case (m_st)
            M_PIN:          if (m_perr != 0) begin em = 2; ev = 1; end
            M_BAL, M_SHOW:  ev = m_bal;
            M_WDR, M_DEP:   ev = m_acc;
            M_CHK:          ev = bcd_ok(sw) ? bcd_val(sw) : 0;
            M_HOLD: begin em = 1; ev = m_amt; eb = (m_el / B) % 2; end
            M_ERR: begin em = 2; ev = m_err; end
            default: ev = 0;
         endcase
         check(cur_req, "model value", int'(disp_value), ev);
         check(cur_req, "model mode", int'(disp_mode), em);
         check(cur_req, "model blank", int'(disp_blank), eb);
      end
   end

   task automatic press(input int k);
      @(negedge clk);
      b[k] = 1'b1;
      @(negedge clk);
      b = '0;
   endtask

   task automatic press_n(input int k, input int n);
      for (int i = 0; i < n; i++) press(k);
   endtask

   task automatic spot(input string req, input int v, input int m, input int bl);
      #1;
      check(req, "value", int'(disp_value), v);
      check(req, "mode", int'(disp_mode), m);
      check(req, "blank", int'(disp_blank), bl);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      cmp_on = 1'b1;
      spot("R1", 0, 0, 0);

      cur_req = "R2";
      sw = 12'h05A; press(4); spot("R2", 1, 2, 0);
      sw = 12'h000; press(4); spot("R2", 0, 0, 0);

      cur_req = "R4";
      press(0); spot("R4", 200, 0, 0);
      press(4); spot("R3", 0, 0, 0);

      cur_req = "R6";
      press(1); press(0); press(0); press(2); spot("R5", 70, 0, 0);
      press(4); spot("R6", 2, 2, 0);
      press(0); spot("R13", 2, 2, 0);
      press(4); spot("R13", 0, 0, 0);
      press(1); spot("R13", 0, 0, 0);
      press_n(3, 6); press(4); spot("R6", 2, 2, 0);
      press(4);

      cur_req = "R7";
      press(1); press_n(3, 2); press_n(1, 3); spot("R5", 260, 0, 0);
      press(4); spot("R7", 3, 2, 0);
      press(4);

      cur_req = "R10";
      press(1); press(3); press_n(1, 2); press(4); spot("R10", 140, 1, 0);
      repeat (4) @(negedge clk); spot("R11", 140, 1, 1);
      press(0);
      repeat (14) @(negedge clk); spot("R10", 60, 0, 0);
      press(4); spot("R3", 0, 0, 0);

      cur_req = "R8";
      press(2); press_n(3, 15); press(4); spot("R8", 4, 2, 0);
      press(4); press(2); spot("R8", 0, 0, 0);
      press_n(3, 10); press(4);
      repeat (H) @(negedge clk); spot("R10", 1060, 0, 0);
      press(4);

      cur_req = "R9";
      sw = 12'h4A0; press(3); spot("R9", 0, 0, 0);
      press(4); spot("R9", 2, 2, 0);
      press(4);
      sw = 12'h441; press(3); spot("R9", 441, 0, 0);
      press(4); spot("R9", 4, 2, 0);
      press(4);
      sw = 12'h440; press(3); press(4); spot("R9", 440, 1, 0);
      repeat (H) @(negedge clk); spot("R14", 1500, 0, 0);
      press(4);

      cur_req = "R5";
      press(1); press_n(3, 41); spot("R5", 4095, 0, 0);
      press(4); spot("R6", 2, 2, 0);
      press(4);

      cur_req = "R12";
      sw = 12'h000; press(4); press(4); spot("R12", 5, 2, 0);
      press(4);
      sw = 12'h03C; press(4); press(4); spot("R12", 0, 0, 0);
      press(4); press(4); spot("R12", 5, 2, 0);
      press(4);

      cur_req = "R1";
      rst = 1'b1; cmp_on = 1'b0;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      spot("R1", 0, 0, 0);
      cmp_on = 1'b1;
      sw = 12'h000; press(4); press(0); spot("R1", 200, 0, 0);

      repeat (2) @(negedge clk);
      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!ended) begin
         ended = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule